// File: doc/BRIEF.md
# Addressed One-Wire Serial Link

This block sends bytes one way over a single wire from one transmitter to four receivers that share the line. The transmitter takes a 2-bit destination and an 8-bit payload on a valid/ready input. It serializes them into a frame: a low start bit, the destination bits, the payload bits and a high stop bit. Each field is sent least significant bit first, and the destination goes before the payload. Each bit lasts `BIT_CYCLES` clock cycles. Between frames the line rests high.

Each receiver has a fixed identity equal to its index. It synchronizes the line and confirms the start bit at half a bit period. It then samples every later bit at mid-period and checks the stop bit. A receiver acts on a frame only when the frame is complete, the stop bit is high and the destination equals its identity. It then sets its match flag to show whether the payload equals the expected byte (0xBB by default). The flag keeps that value until the receiver accepts another frame.

Back-pressure rules on the input: a transfer takes place on a rising edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low for the whole time a frame is on the wire. While `tx_valid` is high and `tx_ready` is low, the source holds the destination and payload steady. The serial output is brought out as `line_out`. The receivers listen on `line_in`, which is normally tied to `line_out`.

Top module: `addr_link_top`

## Requirements
- R1: After reset, `line_out` is high, `tx_ready` is high and every bit of `match` is 0. `line_out` stays high whenever no frame is being sent.
- R2: A frame sends these bits in order on `line_out`: start bit 0, destination bit 0, destination bit 1, payload bits 0 through 7, and stop bit 1. Each bit lasts `BIT_CYCLES` cycles. The start bit appears in the cycle after the transfer.
- R3: In the cycle after a transfer, `tx_ready` drops. While `tx_ready` is low, a held `tx_valid` does not start a new frame. The held item is sent once `tx_ready` returns high.
- R4: When receiver k gets a frame with destination k and payload 0xBB, `match[k]` becomes 1.
- R5: When receiver k gets a frame with destination k and any other payload, `match[k]` becomes 0.
- R6: A frame addressed to another destination leaves `match[k]` unchanged.
- R7: A frame whose stop bit is read as 0 is discarded. No bit of `match` changes.
- R8: A `match` bit keeps its value until its receiver accepts another frame.
- R9: A low pulse on `line_in` shorter than half a bit period is not taken as a start bit. It does not disturb the reception of the next frame.
- R10: `tx_ready` stays low for exactly 12 × `BIT_CYCLES` cycles per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Source has a destination and payload to send |
| tx_ready | output | 1 | Transmitter idle and able to take an item |
| tx_addr | input | 2 | Destination of the item |
| tx_data | input | 8 | Payload of the item |
| line_out | output | 1 | Serial line driven by the transmitter |
| line_in | input | 1 | Serial line seen by the receivers |
| match | output | 4 | One flag per receiver: last accepted payload equalled the expected byte |

## Verification
A well-formed transmitter never produces a frame with a low stop bit or a start pulse that is too short. The two cases that are hardest to reach are therefore the discarded frame and the rejected start glitch. The bench routes `line_in` away from `line_out` and drives the wire bit by bit. It first sends a frame that sets a flag. It then injects a frame to the same receiver with a different payload but a low stop bit, and checks that the flag is unchanged. After that it injects the same frame with a good stop bit to prove the injection path works. Separately, it injects a two-cycle low pulse and follows it with a real frame.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_state_e;

  function automatic int frame_len(input int aw, input int dw);
    return aw + dw + 2;
  endfunction
endpackage

// File: rtl/link_tx.sv
module link_tx #(
  parameter int AW         = 2,
  parameter int DW         = 8,
  parameter int BIT_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          ser_out
);
  localparam int FL = link_pkg::frame_len(AW, DW);
  localparam int CW = $clog2(BIT_CYCLES);
  localparam int IW = $clog2(FL);

  logic          busy_q;
  logic [FL-1:0] shift_q;
  logic [CW-1:0] cyc_q;
  logic [IW-1:0] idx_q;
  logic          line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      shift_q <= '0;
      cyc_q   <= '0;
      idx_q   <= '0;
      line_q  <= 1'b1;
    end else if (!busy_q) begin
      if (in_valid) begin
        busy_q  <= 1'b1;
        shift_q <= {1'b1, in_data, in_addr, 1'b0};
        line_q  <= 1'b0;
        cyc_q   <= '0;
        idx_q   <= '0;
      end
    end else if (cyc_q == CW'(BIT_CYCLES - 1)) begin
      cyc_q <= '0;
      if (idx_q == IW'(FL - 1)) begin
        busy_q <= 1'b0;
        line_q <= 1'b1;
      end else begin
        idx_q   <= idx_q + 1'b1;
        shift_q <= {1'b1, shift_q[FL-1:1]};
        line_q  <= shift_q[1];
      end
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign in_ready = !busy_q;
  assign ser_out  = line_q;
endmodule

// File: rtl/link_rx.sv
module link_rx #(
  parameter int          AW         = 2,
  parameter int          DW         = 8,
  parameter int          BIT_CYCLES = 16,
  parameter int          ID         = 0,
  parameter logic [7:0]  EXPECT     = 8'hBB
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic hit,
  output logic accept
);
  import link_pkg::*;

  localparam int FW   = AW + DW;
  localparam int CW   = $clog2(BIT_CYCLES);
  localparam int IW   = $clog2(FW);
  localparam int HALF = BIT_CYCLES / 2;

  logic [1:0]    sync_q;
  logic          line_s;
  rx_state_e     state_q;
  logic [CW-1:0] cyc_q;
  logic [IW-1:0] idx_q;
  logic [FW-1:0] shift_q;
  logic          hit_q;
  logic          acc_q;

  assign line_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cyc_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      hit_q   <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      acc_q <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          cyc_q <= '0;
          if (!line_s) state_q <= RX_START;
        end
        RX_START: begin
          if (cyc_q == CW'(HALF - 1)) begin
            cyc_q   <= '0;
            idx_q   <= '0;
            state_q <= line_s ? RX_IDLE : RX_BITS;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        RX_BITS: begin
          if (cyc_q == CW'(BIT_CYCLES - 1)) begin
            cyc_q   <= '0;
            shift_q <= {line_s, shift_q[FW-1:1]};
            if (idx_q == IW'(FW - 1)) state_q <= RX_STOP;
            else                      idx_q   <= idx_q + 1'b1;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cyc_q == CW'(BIT_CYCLES - 1)) begin
            cyc_q   <= '0;
            state_q <= RX_IDLE;
            if (line_s && (shift_q[AW-1:0] == AW'(ID))) begin
              hit_q <= (shift_q[FW-1:AW] == EXPECT[DW-1:0]);
              acc_q <= 1'b1;
            end
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign hit    = hit_q;
  assign accept = acc_q;
endmodule

// File: rtl/addr_link_top.sv
module addr_link_top #(
  parameter int         AW         = 2,
  parameter int         DW         = 8,
  parameter int         BIT_CYCLES = 16,
  parameter logic [7:0] EXPECT     = 8'hBB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [AW-1:0]     tx_addr,
  input  logic [DW-1:0]     tx_data,
  output logic              line_out,
  input  logic              line_in,
  output logic [(1<<AW)-1:0] match
);
  localparam int NRX       = 1 << AW;
  localparam int FRAME_LEN = link_pkg::frame_len(AW, DW);

  logic [NRX-1:0] rx_accept;

  link_tx #(.AW(AW), .DW(DW), .BIT_CYCLES(BIT_CYCLES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_addr  (tx_addr),
    .in_data  (tx_data),
    .ser_out  (line_out)
  );

  for (genvar g = 0; g < NRX; g++) begin : g_rx
    link_rx #(
      .AW(AW), .DW(DW), .BIT_CYCLES(BIT_CYCLES), .ID(g), .EXPECT(EXPECT)
    ) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .ser_in (line_in),
      .hit    (match[g]),
      .accept (rx_accept[g])
    );
  end
endmodule

// File: rtl/addr_link_chk.sv
module addr_link_chk #(
  parameter int NRX        = 4,
  parameter int BIT_CYCLES = 16,
  parameter int FL         = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic           line_out,
  input logic [NRX-1:0] match,
  input logic [NRX-1:0] rx_accept
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_cnt <= '0;
    else if (tx_ready) busy_cnt <= '0;
    else               busy_cnt <= busy_cnt + 1'b1;
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> line_out);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_ready) |-> !line_out);

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R8
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match != $past(match)) |-> ((match ^ $past(match)) & ~rx_accept) == '0);

  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> (busy_cnt == 32'(FL * BIT_CYCLES)));
endmodule

bind addr_link_top addr_link_chk #(
  .NRX(NRX), .BIT_CYCLES(BIT_CYCLES), .FL(FRAME_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .line_out  (line_out),
  .match     (match),
  .rx_accept (rx_accept)
);

// File: tb/test_addr_link_top.sv
module test_addr_link_top;
  localparam int B  = 16;
  localparam int NV = 7;
  localparam logic [9:0] VEC [NV] = '{
    {2'd1, 8'hBB}, {2'd2, 8'h3C}, {2'd2, 8'hBB}, {2'd0, 8'hBB},
    {2'd1, 8'h00}, {2'd3, 8'hBB}, {2'd0, 8'hBD}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [1:0] tx_addr = '0;
  logic [7:0] tx_data = '0;
  logic       line_out;
  logic       line_in;
  logic [3:0] match;
  logic       sel = 1'b0;
  logic       drv = 1'b1;
  logic [3:0] exp_m = '0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;
  assign line_in = sel ? drv : line_out;

  addr_link_top #(.BIT_CYCLES(B)) i_addr_link_top (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_addr(tx_addr), .tx_data(tx_data), .line_out(line_out),
    .line_in(line_in), .match(match)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [1:0] a, input logic [7:0] d);
    logic [11:0] fr;
    int n;
    fr = {1'b1, d, a, 1'b0};
    @(negedge clk);
    tx_valid = 1'b1; tx_addr = a; tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    n = 0;
    while (!tx_ready) begin
      if (n % B == B / 2) chk("R2 line bit", 32'(line_out), 32'(fr[n / B]));
      n++;
      @(negedge clk);
    end
    chk("R10 busy length", 32'(n), 32'(12 * B));
    repeat (2) @(negedge clk);
    exp_m[a] = (d == 8'hBB);
  endtask

  task automatic inject(input logic [1:0] a, input logic [7:0] d, input logic stp);
    logic [11:0] fr;
    fr = {stp, d, a, 1'b0};
    @(negedge clk);
    sel = 1'b1;
    for (int k = 0; k < 12; k++) begin
      drv = fr[k];
      repeat (B) @(negedge clk);
    end
    drv = 1'b1;
    repeat (2 * B) @(negedge clk);
    sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset line", 32'(line_out), 32'd1);
    chk("R1 reset ready", 32'(tx_ready), 32'd1);
    chk("R1 reset match", 32'(match), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle line", 32'(line_out), 32'd1);

    // R4 R5 R6 R8: table walk against a model of the flags
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][9:8], VEC[i][7:0]);
      chk("R4/R5/R6/R8 match vector", 32'(match), 32'(exp_m));
    end

    // R7: frame with low stop bit discarded
    send(2'd3, 8'hBB);
    inject(2'd3, 8'h00, 1'b0);
    chk("R7 framing error ignored", 32'(match), 32'(exp_m));
    inject(2'd3, 8'h00, 1'b1);
    exp_m[3] = 1'b0;
    chk("R5 injected good frame", 32'(match), 32'(exp_m));

    // R9: short low glitch rejected, next frame still received
    @(negedge clk);
    sel = 1'b1; drv = 1'b0;
    repeat (2) @(negedge clk);
    drv = 1'b1;
    repeat (3 * B) @(negedge clk);
    sel = 1'b0;
    chk("R9 glitch no change", 32'(match), 32'(exp_m));
    send(2'd0, 8'hBB);
    chk("R9 frame after glitch", 32'(match), 32'(exp_m));

    // R3: back-pressure, held item waits for ready
    @(negedge clk);
    tx_valid = 1'b1; tx_addr = 2'd2; tx_data = 8'h11;
    @(negedge clk);
    tx_addr = 2'd1; tx_data = 8'hBB;
    chk("R3 ready low after transfer", 32'(tx_ready), 32'd0);
    repeat (5 * B) @(negedge clk);
    chk("R3 held valid waits", 32'(tx_ready), 32'd0);
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R3 held item taken", 32'(tx_ready), 32'd0);
    while (!tx_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    exp_m[2] = 1'b0; exp_m[1] = 1'b1;
    chk("R3 both items delivered", 32'(match), 32'(exp_m));
    chk("R1 idle after frames", 32'(line_out), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule